// File: doc/BRIEF.md
# Audio Clock Presence Monitor with Resync Muting

This block sits beside a serial audio receiver and watches the three clocks that feed it: the audio system clock, the bit clock and the word clock. All three arrive as plain signals and are sampled by a faster free-running monitor clock. If any of them stops toggling, or if the number of monitor cycles in one word-clock period moves away from the previous period by more than a small tolerance, the block places the receiver datapath in hold and mutes the audio.

Once every clock is toggling again, the block re-aligns to the rising edge of the word clock. It issues a one-cycle resync pulse after at most three word-clock rising edges. It then keeps the output muted for a guard of three more sample periods before it lets audio through. The mute forces the sample output to two's-complement zero, which is the mid-scale (bipolar zero) code. Recovery runs by itself: after power-up reset, no further reset is needed for any fault.

Top module: `audio_clk_guard`

## Requirements
- R1: After reset, hold_o and mute_o are 1, resync_o is 0 and sample_out is all zeros.
- R2: If the system clock input or the bit clock input shows no edge for more than its timeout (SCK_LIMIT or BCK_LIMIT monitor cycles), hold_o and mute_o become 1. The two rise in the same cycle when leaving normal operation.
- R3: A sample period is the span between two rising (0 to 1) edges of the word clock. When a measured period differs from the one before it by more than TOL monitor cycles, hold_o becomes 1.
- R4: If the word clock shows no edge for LRCK_LIMIT monitor cycles, hold_o and mute_o become 1.
- R5: Once all clocks toggle steadily again, resync_o pulses high for exactly one cycle within three word-clock rising edges. hold_o falls in that same cycle.
- R6: After a resync pulse, mute_o stays 1 until exactly GUARD_FRAMES (default 3) further word-clock rising edges have passed, and then falls to 0.
- R7: A fault during the guard period raises hold_o again while mute_o stays 1. A fresh resync and a full guard follow.
- R8: Whenever hold_o is 1, mute_o is 1. Whenever mute_o is 1, sample_out is all zeros.
- R9: While mute_o is 0, sample_out equals the sample_in value of the previous monitor clock cycle.
- R10: Every recovery completes with rst held low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running monitor clock, faster than twice the system clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sck_in | input | 1 | Audio system clock, sampled as data |
| bck_in | input | 1 | Serial bit clock, sampled as data |
| lrck_in | input | 1 | Word (left/right) clock, sampled as data |
| sample_in | input | DATA_W | Decoded audio sample from the receiver |
| sample_out | output | DATA_W | Sample passed through, or zero while muted |
| hold_o | output | 1 | Datapath hold request (fault or realignment) |
| mute_o | output | 1 | Output forced to mid-scale |
| resync_o | output | 1 | One-cycle pulse when realignment completes |

## Verification
The assertions check several relations on every cycle:
- a detected clock loss or bad period is followed by hold;
- hold always implies mute;
- mute always implies a zero output;
- the resync pulse lasts one cycle and coincides with the release of hold;
- the guard counter stays in range.

Only the bench scenarios can show the parts that unfold over whole sample periods. These are the ordering of hold, resync and mute events for each kind of fault, the bound of three word-clock edges to resync, the exact three-edge guard, a fault inside the guard, and recovery for both rate directions, all without reset.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HOLD   = 2'd1,
    ST_RESYNC = 2'd2,
    ST_GUARD  = 2'd3
  } mon_state_e;

  localparam int NUM_CLKS = 3;
  localparam int IDX_SCK  = 0;
  localparam int IDX_BCK  = 1;
  localparam int IDX_LRCK = 2;
endpackage

// File: rtl/clk_presence.sv
module clk_presence
  import clkmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SCK_LIMIT   = 16,
  parameter int BCK_LIMIT   = 64,
  parameter int LRCK_LIMIT  = 4096
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CLKS-1:0] clk_sig,
  output logic [NUM_CLKS-1:0] lost,
  output logic                word_rise
);
  localparam int MAX_LIM = (LRCK_LIMIT > BCK_LIMIT) ?
                           ((LRCK_LIMIT > SCK_LIMIT) ? LRCK_LIMIT : SCK_LIMIT) :
                           ((BCK_LIMIT > SCK_LIMIT) ? BCK_LIMIT : SCK_LIMIT);
  localparam int CW = $clog2(MAX_LIM + 1);

  logic [SYNC_STAGES:0] shreg [NUM_CLKS];
  logic [NUM_CLKS-1:0]  edge_q;
  logic [CW-1:0]        quiet [NUM_CLKS];

  for (genvar g = 0; g < NUM_CLKS; g++) begin : g_lane
    localparam int LIM = (g == IDX_SCK) ? SCK_LIMIT :
                         (g == IDX_BCK) ? BCK_LIMIT : LRCK_LIMIT;

    always_ff @(posedge clk) begin
      if (rst) begin
        shreg[g]  <= '0;
        edge_q[g] <= 1'b0;
        quiet[g]  <= '0;
      end else begin
        shreg[g]  <= {shreg[g][SYNC_STAGES-1:0], clk_sig[g]};
        edge_q[g] <= shreg[g][SYNC_STAGES] ^ shreg[g][SYNC_STAGES-1];
        if (edge_q[g])
          quiet[g] <= '0;
        else if (quiet[g] != CW'(LIM))
          quiet[g] <= quiet[g] + 1'b1;
      end
    end

    assign lost[g] = (quiet[g] == CW'(LIM));

    // R2 / R4: an observed edge always clears the loss flag of its lane
    a_r2_edge_clears_loss: assert property (@(posedge clk) disable iff (rst)
      edge_q[g] |=> !lost[g]);
    // R4: loss persists until the next edge arrives
    a_r4_loss_sticky: assert property (@(posedge clk) disable iff (rst)
      (lost[g] && !edge_q[g]) |=> lost[g]);
  end

  always_ff @(posedge clk) begin
    if (rst)
      word_rise <= 1'b0;
    else
      word_rise <= !shreg[IDX_LRCK][SYNC_STAGES] && shreg[IDX_LRCK][SYNC_STAGES-1];
  end
endmodule

// File: rtl/period_check.sv
module period_check #(
  parameter int PER_W = 14,
  parameter int TOL   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic clr,
  output logic frame_ok,
  output logic frame_bad
);
  localparam logic [PER_W-1:0] PMAX = '1;

  logic [PER_W-1:0] span, last_span, diff;
  logic             armed, have_last;

  always_comb begin
    if (span > last_span) diff = span - last_span;
    else                  diff = last_span - span;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      span      <= '0;
      last_span <= '0;
      armed     <= 1'b0;
      have_last <= 1'b0;
      frame_ok  <= 1'b0;
      frame_bad <= 1'b0;
    end else begin
      frame_ok  <= 1'b0;
      frame_bad <= 1'b0;
      if (rise) begin
        if (armed && !clr && have_last) begin
          if (diff > PER_W'(TOL)) frame_bad <= 1'b1;
          else                    frame_ok  <= 1'b1;
        end
        have_last <= armed && !clr;
        last_span <= span;
        armed     <= 1'b1;
        span      <= PER_W'(1);
      end else begin
        if (clr) begin
          armed     <= 1'b0;
          have_last <= 1'b0;
        end
        if (span != PMAX) span <= span + 1'b1;
      end
    end
  end

  // R3: a verdict is only given once a reference period exists
  a_r3_verdict_needs_ref: assert property (@(posedge clk) disable iff (rst)
    (frame_ok || frame_bad) |-> $past(have_last));
endmodule

// File: rtl/recover_fsm.sv
module recover_fsm
  import clkmon_pkg::*;
#(
  parameter int GUARD_FRAMES  = 3,
  parameter int STABLE_FRAMES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic any_lost,
  input  logic frame_ok,
  input  logic frame_bad,
  output logic mute_next,
  output logic hold_q,
  output logic mute_q,
  output logic resync_q
);
  localparam int CNT_MAX = (GUARD_FRAMES > STABLE_FRAMES) ? GUARD_FRAMES : STABLE_FRAMES;
  localparam int FW      = $clog2(CNT_MAX + 1);

  mon_state_e state, nxt;
  logic [FW-1:0] fcnt;
  logic          fault;

  assign fault = any_lost || frame_bad;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:    if (fault) nxt = ST_HOLD;
      ST_HOLD:   if (!fault) nxt = ST_RESYNC;
      ST_RESYNC: if (fault) nxt = ST_HOLD;
                 else if (frame_ok && fcnt == FW'(STABLE_FRAMES - 1)) nxt = ST_GUARD;
      ST_GUARD:  if (fault) nxt = ST_HOLD;
                 else if (frame_ok && fcnt == FW'(GUARD_FRAMES - 1)) nxt = ST_RUN;
      default:   nxt = ST_HOLD;
    endcase
  end

  assign mute_next = (nxt != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HOLD;
      fcnt     <= '0;
      hold_q   <= 1'b1;
      mute_q   <= 1'b1;
      resync_q <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state)
        fcnt <= '0;
      else if (frame_ok && (state == ST_RESYNC || state == ST_GUARD))
        fcnt <= fcnt + 1'b1;
      hold_q   <= (nxt == ST_HOLD) || (nxt == ST_RESYNC);
      mute_q   <= mute_next;
      resync_q <= (state == ST_RESYNC) && (nxt == ST_GUARD);
    end
  end

  a_r2_loss_forces_hold: assert property (@(posedge clk) disable iff (rst)
    any_lost |=> (hold_q && mute_q));
  a_r3_bad_period_holds: assert property (@(posedge clk) disable iff (rst)
    frame_bad |=> hold_q);
  a_r8_hold_implies_mute: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> mute_q);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    resync_q |=> !resync_q);
  a_r5_pulse_releases_hold: assert property (@(posedge clk) disable iff (rst)
    resync_q |-> (!hold_q && mute_q && $past(hold_q)));
  a_r6_count_in_range: assert property (@(posedge clk) disable iff (rst)
    fcnt < FW'(CNT_MAX));
endmodule

// File: rtl/audio_clk_guard.sv
module audio_clk_guard
  import clkmon_pkg::*;
#(
  parameter int DATA_W        = 24,
  parameter int SYNC_STAGES   = 2,
  parameter int SCK_LIMIT     = 16,
  parameter int BCK_LIMIT     = 64,
  parameter int LRCK_LIMIT    = 4096,
  parameter int PER_W         = 14,
  parameter int TOL           = 4,
  parameter int GUARD_FRAMES  = 3,
  parameter int STABLE_FRAMES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_in,
  input  logic              bck_in,
  input  logic              lrck_in,
  input  logic [DATA_W-1:0] sample_in,
  output logic [DATA_W-1:0] sample_out,
  output logic              hold_o,
  output logic              mute_o,
  output logic              resync_o
);
  logic [NUM_CLKS-1:0] clk_vec, lost;
  logic                word_rise, frame_ok, frame_bad, mute_next;

  assign clk_vec = {lrck_in, bck_in, sck_in};

  clk_presence #(
    .SYNC_STAGES(SYNC_STAGES),
    .SCK_LIMIT  (SCK_LIMIT),
    .BCK_LIMIT  (BCK_LIMIT),
    .LRCK_LIMIT (LRCK_LIMIT)
  ) u_presence (
    .clk      (clk),
    .rst      (rst),
    .clk_sig  (clk_vec),
    .lost     (lost),
    .word_rise(word_rise)
  );

  period_check #(
    .PER_W(PER_W),
    .TOL  (TOL)
  ) u_period (
    .clk      (clk),
    .rst      (rst),
    .rise     (word_rise),
    .clr      (lost[IDX_LRCK]),
    .frame_ok (frame_ok),
    .frame_bad(frame_bad)
  );

  recover_fsm #(
    .GUARD_FRAMES (GUARD_FRAMES),
    .STABLE_FRAMES(STABLE_FRAMES)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .any_lost (|lost),
    .frame_ok (frame_ok),
    .frame_bad(frame_bad),
    .mute_next(mute_next),
    .hold_q   (hold_o),
    .mute_q   (mute_o),
    .resync_q (resync_o)
  );

  always_ff @(posedge clk) begin
    if (rst)            sample_out <= '0;
    else if (mute_next) sample_out <= '0;
    else                sample_out <= sample_in;
  end

  a_r8_muted_output_zero: assert property (@(posedge clk) disable iff (rst)
    mute_o |-> (sample_out == '0));
  a_r9_passthrough: assert property (@(posedge clk) disable iff (rst)
    (!mute_o && $past(!rst)) |-> (sample_out == $past(sample_in)));
endmodule

// File: tb/test_audio_clk_guard.sv
`timescale 1ns/1ps
module test_audio_clk_guard;
  localparam int DW = 24;
  localparam int EV_MUTE_RISE = 1, EV_HOLD_RISE = 2, EV_RESYNC = 3,
                 EV_HOLD_FALL = 4, EV_MUTE_FALL = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, bck = 1'b0, lrck = 1'b0;
  logic [DW-1:0] sin = '0;
  logic [DW-1:0] sout;
  logic hold, mute, rsy;

  int checks = 0, errors = 0;
  int exp_q[$];
  bit sck_on = 0, bck_on = 0, lr_on = 0, mon_en = 0, done = 0;
  int frame_bits = 32, bdiv = 0, bitcnt = 0;
  int lr_rises = 0, rs_mark = 0, g_mark = 0, resync_seen = 0;
  logic p_hold = 1'b1, p_mute = 1'b1;

  always #2 clk = ~clk;

  audio_clk_guard #(
    .DATA_W(DW), .SYNC_STAGES(2), .SCK_LIMIT(8), .BCK_LIMIT(16),
    .LRCK_LIMIT(300), .PER_W(12), .TOL(4), .GUARD_FRAMES(3), .STABLE_FRAMES(1)
  ) i_audio_clk_guard (
    .clk(clk), .rst(rst), .sck_in(sck), .bck_in(bck), .lrck_in(lrck),
    .sample_in(sin), .sample_out(sout), .hold_o(hold), .mute_o(mute), .resync_o(rsy)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic take(int code, string req);
    int e;
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL %s unexpected event actual %0d expected none", req, code);
    end else begin
      e = exp_q.pop_front();
      check(req, "event order", code, e);
    end
  endtask

  task automatic push_fault();
    exp_q.push_back(EV_MUTE_RISE);
    exp_q.push_back(EV_HOLD_RISE);
  endtask

  task automatic push_recover();
    exp_q.push_back(EV_RESYNC);
    exp_q.push_back(EV_HOLD_FALL);
    exp_q.push_back(EV_MUTE_FALL);
  endtask

  task automatic drain(string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(req, "pending events", exp_q.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic passthrough(string req, int n, int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sin = DW'(seed * 40503 + i * 977 + 3);
      @(negedge clk);
      check(req, "sample passthrough", sout, sin);
    end
  endtask

  task automatic muted_out(string req);
    @(negedge clk);
    sin = 24'h5A5A5A;
    @(negedge clk);
    @(negedge clk);
    check(req, "muted output", sout, 0);
  endtask

  // clock generator: sck half period 1 clk, bck half period 2 clk
  initial begin
    forever begin
      @(negedge clk);
      if (sck_on) sck = ~sck;
      if (bck_on) begin
        bdiv++;
        if (bdiv == 2) begin
          bdiv = 0;
          bck = ~bck;
          if (!bck) begin
            bitcnt++;
            if (bitcnt >= frame_bits / 2) begin
              bitcnt = 0;
              if (lr_on) begin
                lrck = ~lrck;
                if (lrck) lr_rises++;
              end
            end
          end
        end
      end
    end
  end

  // monitor: pops the scoreboard in fixed intra-cycle order
  always @(negedge clk) begin
    if (mon_en) begin
      if (mute && !p_mute) take(EV_MUTE_RISE, "R2");
      if (hold && !p_hold) take(EV_HOLD_RISE, "R2");
      if (rsy) begin
        take(EV_RESYNC, "R5");
        check("R5", "word edges to resync within 3", (lr_rises - rs_mark) <= 3, 1);
        g_mark = lr_rises;
        resync_seen++;
      end
      if (!hold && p_hold) take(EV_HOLD_FALL, "R5");
      if (!mute && p_mute) begin
        take(EV_MUTE_FALL, "R6");
        check("R6", "guard word edges", lr_rises - g_mark, 3);
      end
      p_hold = hold;
      p_mute = mute;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    check("R1", "hold after reset", hold, 1);
    check("R1", "mute after reset", mute, 1);
    check("R1", "resync after reset", rsy, 0);
    check("R1", "output after reset", sout, 0);
    rst = 1'b0;
    mon_en = 1;

    // start-up recovery
    push_recover();
    rs_mark = lr_rises;
    sck_on = 1; bck_on = 1; lr_on = 1;
    drain("R5");
    passthrough("R9", 8, 1);

    // R2: bit clock stops
    push_fault();
    bck_on = 0;
    repeat (60) @(negedge clk);
    check("R2", "hold on bit clock loss", hold, 1);
    check("R2", "mute on bit clock loss", mute, 1);
    muted_out("R8");
    push_recover();
    rs_mark = lr_rises;
    bck_on = 1;
    drain("R6");

    // R2: system clock stops
    push_fault();
    sck_on = 0;
    repeat (40) @(negedge clk);
    check("R2", "hold on system clock loss", hold, 1);
    muted_out("R8");
    push_recover();
    rs_mark = lr_rises;
    sck_on = 1;
    drain("R6");
    passthrough("R9", 4, 2);

    // R3: rate goes up then back down
    push_fault();
    push_recover();
    rs_mark = lr_rises;
    frame_bits = 48;
    drain("R3");
    push_fault();
    push_recover();
    rs_mark = lr_rises;
    frame_bits = 32;
    drain("R3");

    // R4: word clock stops while bit clock runs
    push_fault();
    lr_on = 0;
    repeat (400) @(negedge clk);
    check("R4", "hold on word clock loss", hold, 1);
    check("R4", "mute on word clock loss", mute, 1);
    push_recover();
    rs_mark = lr_rises;
    lr_on = 1;
    drain("R4");

    // R7: fault inside the guard period
    push_fault();
    exp_q.push_back(EV_RESYNC);
    exp_q.push_back(EV_HOLD_FALL);
    bck_on = 0;
    repeat (60) @(negedge clk);
    rs_mark = lr_rises;
    bck_on = 1;
    @(negedge clk);
    while (!rsy) @(negedge clk);
    exp_q.push_back(EV_HOLD_RISE);
    repeat (20) @(negedge clk);
    bck_on = 0;
    repeat (60) @(negedge clk);
    check("R7", "hold re-raised in guard", hold, 1);
    check("R7", "mute kept in guard", mute, 1);
    push_recover();
    rs_mark = lr_rises;
    bck_on = 1;
    drain("R7");
    passthrough("R9", 4, 3);

    check("R10", "recoveries without reset", resync_seen, 8);
    check("R10", "reset stayed low", rst, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule